// File: doc/BRIEF.md
# Clock Frequency Range Checker

This block watches several slow clocks against a fast reference clock and reports any whose frequency drifts out of range. For each channel it counts rising edges of the watched clock over a fixed window of `WIN_LEN` reference cycles. At the end of the window it compares the count with a programmed minimum and maximum. A count outside that range sets a measurement error. A channel that shows no edge for two whole windows sets a timeout error. The watched clocks are brought into the reference domain through plain flop synchronizers, so each must run at less than half the reference rate.

Each channel has a 4-bit multibit enable and a threshold register. The threshold register is protected by a shadow: it commits only on two matching writes, and the committed copy is checked against an inverted twin. One write-lock bit freezes every enable and every threshold. The error bits are sticky and clear when 1 is written to them. Any set error bit drives the recoverable alert. A corrupted threshold store drives the fatal alert. Software reaches the block through a plain word-addressed register port. There is no stream traffic, so there is no valid/ready handshake and no back-pressure.

Register map, by word address, where N is `NUM_CLK`:
- 0: lock bit.
- 1+2i: enable of channel i.
- 2+2i: threshold of channel i.
- 2N+1: recoverable error code.
- 2N+2: fatal error code.

Top module: `clk_freq_checker`

## Requirements
- R1: After reset, the lock bit reads 1 and every enable reads 0x9. Every threshold reads {min 0x1D6, max 0x1EA}, which is 0x759EA. Both error codes read 0 and both alerts are low.
- R2: Writing the lock with bit 0 = 0 clears it. Writing 1 never sets it again. While the lock is 0, writes to enables and thresholds leave their read-back values unchanged.
- R3: A threshold write commits only when two consecutive writes to that register carry equal data. After the first write alone, the old value still reads back.
- R4: If the second write differs from the first, error bit 0 is set and the committed value is kept. The next write starts a fresh pair.
- R5: A channel measures only when its enable holds 0x6. Any other value, including the reset value 0x9, raises no error on that channel.
- R6: The maximum sits in threshold bits [CNT_W-1:0] and the minimum in bits [2*CNT_W-1:CNT_W]. A window count with min <= count <= max raises no error.
- R7: A window count below the minimum or above the maximum sets error bit 1+i for channel i.
- R8: An enabled channel with no edge for 2*WIN_LEN reference cycles sets error bit 1+N+i. A channel whose edges keep arriving never sets it.
- R9: Error bits are sticky. Writing a 1 to a bit of the error code clears that bit. Writing 0 leaves it unchanged.
- R10: The recoverable alert is high exactly when some recoverable error bit is set.
- R11: If a committed threshold disagrees with its inverted copy, fatal code bit 0 is set and the fatal alert rises. Neither can be cleared by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mon_clk_i | input | NUM_CLK | Watched clocks, one per channel |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wdata_i | input | 2*CNT_W | Write data |
| reg_rdata_o | output | 2*CNT_W | Read data for reg_addr_i (combinational) |
| recov_alert_o | output | 1 | Any recoverable error pending |
| fatal_alert_o | output | 1 | Threshold storage corruption seen |

## Verification
The assertions take for granted that each watched clock runs at less than half the reference rate. Under that condition every edge seen by the synchronizer is a real edge. They also take for granted that `WIN_LEN` is at least 2, so an end-of-window pulse lasts exactly one cycle. The stimulus drives each watched clock as a square wave with a half period of two or more reference cycles, set from inside the bench. It changes a channel's thresholds only while that channel is disabled. The storage fault is the one stimulus that does not arrive through the ports: it is forced onto the inverted copy.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  typedef logic [3:0] mubi4_t;
  localparam mubi4_t MUBI4_TRUE  = 4'h6;
  localparam mubi4_t MUBI4_FALSE = 4'h9;

  function automatic logic mubi4_on(input mubi4_t v);
    return v == MUBI4_TRUE;
  endfunction
endpackage

// File: rtl/cfc_shadow_reg.sv
module cfc_shadow_reg #(
  parameter int unsigned W = 20,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o,
  output logic         upd_err_o,
  output logic         stor_err_o
);
  logic         phase_q;
  logic [W-1:0] stage_q;
  logic [W-1:0] q;
  logic [W-1:0] inv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      stage_q <= '0;
      q       <= RST;
      inv_q   <= ~RST;
    end else if (we_i) begin
      if (!phase_q) begin
        stage_q <= wdata_i;
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        if (wdata_i == stage_q) begin
          q     <= wdata_i;
          inv_q <= ~wdata_i;
        end
      end
    end
  end

  assign q_o        = q;
  assign upd_err_o  = we_i && phase_q && (wdata_i != stage_q);
  assign stor_err_o = (q != ~inv_q);

  a_r3_commit_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && phase_q && wdata_i == stage_q) |=> (q_o == $past(wdata_i)));
  a_r4_mismatch_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && phase_q && wdata_i != stage_q) |=> $stable(q_o));
  a_r3_first_write_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !phase_q) |=> $stable(q_o));
endmodule

// File: rtl/cfc_meas_unit.sv
module cfc_meas_unit #(
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned WIN_LEN = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mon_clk_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic             meas_err_o,
  output logic             tmo_o
);
  localparam int unsigned WIN_W   = $clog2(WIN_LEN);
  localparam int unsigned TMO_LEN = 2 * WIN_LEN;
  localparam int unsigned IDLE_W  = $clog2(TMO_LEN + 1);

  logic [2:0]        sync_q;
  logic              mon_rise;
  logic [WIN_W-1:0]  win_q;
  logic              win_end;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDLE_W-1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], mon_clk_i};
  end
  assign mon_rise = sync_q[1] & ~sync_q[2];

  assign win_end = en_i && (win_q == WIN_W'(WIN_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
    end else if (!en_i || win_end) begin
      win_q <= '0;
    end else begin
      win_q <= win_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i || win_end) begin
      cnt_q <= '0;
    end else if (mon_rise && cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
    end else if (!en_i || mon_rise) begin
      idle_q <= '0;
    end else if (idle_q != IDLE_W'(TMO_LEN)) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  assign meas_err_o = win_end && ((cnt_q < lo_i) || (cnt_q > hi_i));
  assign tmo_o      = en_i && !mon_rise && (idle_q == IDLE_W'(TMO_LEN - 1));

  a_r8_edge_blocks_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mon_rise |=> !tmo_o);
  a_r7_one_report_per_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_err_o |=> !meas_err_o);
  a_r5_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!meas_err_o && !tmo_o));
endmodule

// File: rtl/clk_freq_checker.sv
module clk_freq_checker
  import cfc_pkg::*;
#(
  parameter int unsigned NUM_CLK    = 2,
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned WIN_LEN    = 64,
  parameter logic [CNT_W-1:0] THR_HI_RST = CNT_W'(10'h1EA),
  parameter logic [CNT_W-1:0] THR_LO_RST = CNT_W'(10'h1D6),
  localparam int unsigned THR_W  = 2 * CNT_W,
  localparam int unsigned ADDR_W = $clog2(2 * NUM_CLK + 3)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CLK-1:0] mon_clk_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [THR_W-1:0]   reg_wdata_i,
  output logic [THR_W-1:0]   reg_rdata_o,
  output logic               recov_alert_o,
  output logic               fatal_alert_o
);
  localparam int unsigned ERR_W      = 1 + 2 * NUM_CLK;
  localparam int unsigned ADDR_LOCK  = 0;
  localparam int unsigned ADDR_ERR   = 2 * NUM_CLK + 1;
  localparam int unsigned ADDR_FATAL = 2 * NUM_CLK + 2;
  localparam logic [THR_W-1:0] THR_RST = {THR_LO_RST, THR_HI_RST};

  logic               lock_q;
  mubi4_t             en_q   [NUM_CLK];
  logic [THR_W-1:0]   thr_q  [NUM_CLK];
  logic [NUM_CLK-1:0] upd_err, stor_err, meas_err, tmo;
  logic [ERR_W-1:0]   err_q, err_set, err_clr;
  logic               fatal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b1;
    end else if (reg_we_i && reg_addr_i == ADDR_W'(ADDR_LOCK) && !reg_wdata_i[0]) begin
      lock_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_ch
    localparam int unsigned A_EN  = 1 + 2 * i;
    localparam int unsigned A_THR = 2 + 2 * i;
    logic thr_we;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[i] <= MUBI4_FALSE;
      end else if (reg_we_i && lock_q && reg_addr_i == ADDR_W'(A_EN)) begin
        en_q[i] <= reg_wdata_i[3:0];
      end
    end

    assign thr_we = reg_we_i && lock_q && (reg_addr_i == ADDR_W'(A_THR));

    cfc_shadow_reg #(.W(THR_W), .RST(THR_RST)) u_thr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (thr_we),
      .wdata_i    (reg_wdata_i),
      .q_o        (thr_q[i]),
      .upd_err_o  (upd_err[i]),
      .stor_err_o (stor_err[i])
    );

    cfc_meas_unit #(.CNT_W(CNT_W), .WIN_LEN(WIN_LEN)) u_meas (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mon_clk_i  (mon_clk_i[i]),
      .en_i       (mubi4_on(en_q[i])),
      .lo_i       (thr_q[i][THR_W-1:CNT_W]),
      .hi_i       (thr_q[i][CNT_W-1:0]),
      .meas_err_o (meas_err[i]),
      .tmo_o      (tmo[i])
    );

    a_r2_locked_enable_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lock_q && reg_we_i && reg_addr_i == ADDR_W'(A_EN)) |=> $stable(en_q[i]));
    a_r2_locked_thr_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lock_q && reg_we_i && reg_addr_i == ADDR_W'(A_THR)) |=> $stable(thr_q[i]));
  end

  assign err_set = {tmo, meas_err, |upd_err};
  assign err_clr = (reg_we_i && reg_addr_i == ADDR_W'(ADDR_ERR)) ? reg_wdata_i[ERR_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= '0;
      fatal_q <= 1'b0;
    end else begin
      err_q   <= (err_q & ~err_clr) | err_set;
      fatal_q <= fatal_q | (|stor_err);
    end
  end

  assign recov_alert_o = |err_q;
  assign fatal_alert_o = fatal_q;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(ADDR_LOCK))  reg_rdata_o[0] = lock_q;
    if (reg_addr_i == ADDR_W'(ADDR_ERR))   reg_rdata_o[ERR_W-1:0] = err_q;
    if (reg_addr_i == ADDR_W'(ADDR_FATAL)) reg_rdata_o[0] = fatal_q;
    for (int i = 0; i < NUM_CLK; i++) begin
      if (reg_addr_i == ADDR_W'(1 + 2 * i)) reg_rdata_o[3:0] = en_q[i];
      if (reg_addr_i == ADDR_W'(2 + 2 * i)) reg_rdata_o = thr_q[i];
    end
  end

  a_r1_lock_stays_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |=> !lock_q);
  a_r9_errors_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == ADDR_W'(ADDR_ERR)) |=> ((err_q & $past(err_q)) == $past(err_q)));
  a_r11_fatal_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_alert_o |=> fatal_alert_o);
endmodule

// File: tb/clk_freq_checker_tb_top.sv
module clk_freq_checker_tb_top;
  localparam int N = 2;
  localparam int W = 64;
  localparam int A_LOCK = 0, A_EN0 = 1, A_THR0 = 2, A_EN1 = 3, A_THR1 = 4, A_ERR = 5, A_FATAL = 6;

  // period, min, max, expected measurement error on channel 0
  localparam logic [31:0] VEC [0:6] = '{
    {8'd4,  8'd14, 8'd18, 8'd0},
    {8'd4,  8'd20, 8'd30, 8'd1},
    {8'd4,  8'd2,  8'd14, 8'd1},
    {8'd8,  8'd6,  8'd10, 8'd0},
    {8'd8,  8'd12, 8'd20, 8'd1},
    {8'd16, 8'd2,  8'd6,  8'd0},
    {8'd16, 8'd5,  8'd9,  8'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] mon = '0;
  logic we = 1'b0;
  logic [2:0] addr = '0;
  logic [19:0] wdata = '0;
  logic [19:0] rdata;
  logic ralert, falert;
  int half_p [N];
  int mcnt [N];
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clk_freq_checker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mon_clk_i(mon),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .recov_alert_o(ralert), .fatal_alert_o(falert)
  );

  initial begin
    for (int c = 0; c < N; c++) begin half_p[c] = 0; mcnt[c] = 0; end
  end

  always @(posedge clk) begin
    for (int c = 0; c < N; c++) begin
      if (half_p[c] == 0) mcnt[c] <= 0;
      else if (mcnt[c] >= half_p[c] - 1) begin mcnt[c] <= 0; mon[c] <= ~mon[c]; end
      else mcnt[c] <= mcnt[c] + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [19:0] d);
    @(negedge clk); we = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [19:0] d);
    @(negedge clk); addr = 3'(a); #1; d = rdata;
  endtask

  task automatic wr_thr(input int a, input logic [19:0] d);
    wr(a, d); wr(a, d);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
    end
  end

  initial begin
    logic [19:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_LOCK, d);  check("R1 lock", 32'(d), 32'h1);
    rd(A_EN0, d);   check("R1 enable0", 32'(d), 32'h9);
    rd(A_EN1, d);   check("R1 enable1", 32'(d), 32'h9);
    rd(A_THR0, d);  check("R1 threshold0", 32'(d), 32'h759EA);
    rd(A_THR1, d);  check("R1 threshold1", 32'(d), 32'h759EA);
    rd(A_ERR, d);   check("R1 error code", 32'(d), 32'h0);
    rd(A_FATAL, d); check("R1 fatal code", 32'(d), 32'h0);
    check("R1 alerts", {30'd0, ralert, falert}, 32'h0);

    // R3 two matching writes commit
    wr(A_THR0, 20'h12345);
    rd(A_THR0, d); check("R3 after first write", 32'(d), 32'h759EA);
    wr(A_THR0, 20'h12345);
    rd(A_THR0, d); check("R3 after second write", 32'(d), 32'h12345);

    // R4 mismatch keeps value and flags
    wr(A_THR0, 20'h11111); wr(A_THR0, 20'h22222);
    rd(A_THR0, d); check("R4 value kept", 32'(d), 32'h12345);
    rd(A_ERR, d);  check("R4 update error bit0", 32'(d), 32'h1);
    wr_thr(A_THR0, 20'h759EA);
    rd(A_THR0, d); check("R4 fresh pair commits", 32'(d), 32'h759EA);
    wr(A_ERR, 20'h1);
    rd(A_ERR, d);  check("R9 write-1 clears bit0", 32'(d), 32'h0);

    // R6 / R7 vector table on channel 0
    for (int v = 0; v < 7; v++) begin
      logic [31:0] e;
      e = VEC[v];
      wr(A_EN0, 20'h9);
      half_p[0] = int'(e[31:24]) / 2;
      wr_thr(A_THR0, {2'b0, e[23:16], 2'b0, e[15:8]});
      wait_cyc(8);
      wr(A_ERR, 20'h1F);
      wr(A_EN0, 20'h6);
      wait_cyc(3 * W + 8);
      rd(A_ERR, d);
      if (e[0]) check("R7 out of range sets bit1", 32'(d[1]), 32'h1);
      else      check("R6 in range no error", 32'(d[1]), 32'h0);
    end
    wr(A_EN0, 20'h9);
    wait_cyc(4);
    wr(A_ERR, 20'h1F);

    // R5 non-true enables raise nothing
    half_p[0] = 2;
    wr_thr(A_THR0, {10'd20, 10'd30});
    wr(A_EN0, 20'hA);
    wait_cyc(3 * W + 8);
    rd(A_ERR, d); check("R5 enable 0xA silent", 32'(d), 32'h0);
    wr(A_EN0, 20'h9);
    wait_cyc(3 * W + 8);
    rd(A_ERR, d); check("R5 enable 0x9 silent", 32'(d), 32'h0);
    wr(A_EN0, 20'h6);
    wait_cyc(2 * W + 8);
    rd(A_ERR, d); check("R5 enable 0x6 measures", 32'(d[1]), 32'h1);
    wr(A_EN0, 20'h9);
    wait_cyc(4);
    wr(A_ERR, 20'h1F);

    // R8 timeout on a stopped channel 1, channel 0 healthy
    wr_thr(A_THR0, {10'd14, 10'd18});
    wr(A_EN0, 20'h6);
    half_p[1] = 0;
    wr_thr(A_THR1, {10'd0, 10'h3FF});
    wr(A_EN1, 20'h6);
    wait_cyc(2 * W - 12);
    rd(A_ERR, d); check("R8 no timeout before two windows", 32'(d[4]), 32'h0);
    wait_cyc(24);
    rd(A_ERR, d);
    check("R8 timeout bit4 set", 32'(d[4]), 32'h1);
    check("R8 healthy channel no timeout", 32'(d[3]), 32'h0);
    check("R6 zero count within range", 32'(d[2]), 32'h0);
    check("R10 alert with error", 32'(ralert), 32'h1);
    wr(A_EN1, 20'h9);
    wr(A_ERR, 20'h0);
    rd(A_ERR, d); check("R9 write-0 keeps bit4", 32'(d[4]), 32'h1);
    wr(A_ERR, 20'h10);
    rd(A_ERR, d); check("R9 write-1 clears bit4", 32'(d), 32'h0);
    check("R10 alert drops", 32'(ralert), 32'h0);
    wr(A_EN0, 20'h9);

    // R2 lock
    wr(A_LOCK, 20'h1);
    rd(A_LOCK, d); check("R2 write 1 keeps lock", 32'(d), 32'h1);
    wr(A_LOCK, 20'h0);
    rd(A_LOCK, d); check("R2 lock cleared", 32'(d), 32'h0);
    wr(A_LOCK, 20'h1);
    rd(A_LOCK, d); check("R2 lock not re-set", 32'(d), 32'h0);
    wr(A_EN0, 20'h6);
    rd(A_EN0, d); check("R2 enable frozen", 32'(d), 32'h9);
    wr_thr(A_THR0, 20'h11111);
    rd(A_THR0, d); check("R2 threshold frozen", 32'({10'd14, 10'd18}), 32'(d));

    // R11 storage fault
    check("R11 fatal low before fault", 32'(falert), 32'h0);
    force dut_i.g_ch[0].u_thr.inv_q = 20'h0;
    wait_cyc(3);
    release dut_i.g_ch[0].u_thr.inv_q;
    rd(A_FATAL, d); check("R11 fatal bit0", 32'(d), 32'h1);
    check("R11 fatal alert", 32'(falert), 32'h1);
    wr(A_FATAL, 20'h0);
    wr(A_ERR, 20'hFFFFF);
    rd(A_FATAL, d); check("R11 fatal not clearable", 32'(d), 32'h1);

    done = 1;
    finish_sim();
  end
endmodule